// File: doc/BRIEF.md
# Shift and Rotate Execution Unit with Carry

This unit performs every shift and rotate an integer datapath needs on byte, half-word or full-word operands. It covers plain rotates and rotates through the carry, logical and arithmetic shifts, and double-operand shifts whose vacated positions are refilled from a second operand. For each operation it defines exactly which bit leaves into the carry and, for rotates through carry, which bit the incoming carry enters.

An operation is issued for one cycle with its opcode, size code, destination value, second operand, raw count and incoming carry. One clock later the unit presents the zero-extended result, the new carry and overflow, and a one-cycle flag-write strobe. The strobe tells the surrounding pipeline whether the flags may be committed. A count that masks to zero, or an unassigned opcode, passes the destination through and leaves the flags alone.

Top module: `shrot_unit`

## Requirements
- R1: Only the low 5 bits of the 8-bit count are used. When they are zero, the result equals the size-masked destination, the carry output equals the incoming carry, overflow is 0 and the flag-write strobe stays low.
- R2: Opcode 0 rotates left and opcode 1 rotates right by the count modulo the operand width. After a left rotate, the carry equals result bit 0. After a right rotate, the carry equals the result's top bit. This holds even when the count is a non-zero multiple of the width.
- R3: Opcodes 2 (left) and 3 (right) rotate through carry on a ring of width+1 bits, so the count acts modulo width+1. On a left rotate the old carry enters bit 0 and the top bit leaves to carry. On a right rotate the old carry enters the top bit and bit 0 leaves to carry.
- R4: Opcodes 4 and 6 are identical left shifts. They fill with zeros, and the carry is the last bit shifted out past the top (0 once the count exceeds the width).
- R5: Opcode 5 is a logical right shift with zero fill. The carry is the last bit shifted out below bit 0.
- R6: Opcode 7 is an arithmetic right shift that keeps refilling the top bit with its old value. The carry is the last bit shifted out (the sign once the count reaches past the width).
- R7: Opcode 8 shifts the destination left and fills the vacated low bits from the second operand's most significant bits. Opcode 9 shifts right and fills the vacated high bits from the second operand's least significant bits. In both cases the carry is the last destination bit shifted out.
- R8: Overflow is 1 only when the masked count is exactly 1 and the result's top bit differs from the destination's original top bit. Otherwise it is 0.
- R9: Size code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 32 bits. Result bits above the selected width are always 0.
- R10: Opcodes 10 to 15 are reserved and behave like a zero count: result = masked destination, carry = incoming carry, overflow 0, no flag write.
- R11: Outputs are registered. They update on the rising edge after an issue cycle and hold otherwise. The flag-write strobe is high for exactly the one cycle after an issue that updates the flags. Reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Operation issued this cycle |
| op_i | input | 4 | Opcode (see R2 to R10) |
| size_i | input | 2 | Operand size code (R9) |
| dst_i | input | 32 | Destination operand |
| src_i | input | 32 | Second operand for double shifts |
| count_i | input | 8 | Raw shift or rotate count |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted or rotated result, zero-extended |
| carry_o | output | 1 | New carry flag |
| ovf_o | output | 1 | New overflow flag |
| flags_we_o | output | 1 | Flags valid, to be committed |

## Verification
The assertions assume the following about the inputs:
- Every operand, the opcode, the size code and the count are stable and known in any cycle where the issue strobe is high.
- Inputs in cycles without an issue are irrelevant.

The bench meets these assumptions by changing every input on the falling clock edge and raising the issue strobe for one cycle per operation. It includes reserved opcodes, size code 3 and counts above 31 on purpose, because the assertions make no assumption about their values. The population-count properties depend only on the destination being held for the issue cycle, so the bench drives them with pseudo-random operands.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

  typedef enum logic [3:0] {
    OP_ROTL = 4'd0,
    OP_ROTR = 4'd1,
    OP_RCYL = 4'd2,
    OP_RCYR = 4'd3,
    OP_SHL  = 4'd4,
    OP_SHR  = 4'd5,
    OP_SAL  = 4'd6,
    OP_SAR  = 4'd7,
    OP_DSHL = 4'd8,
    OP_DSHR = 4'd9
  } shop_e;

  localparam logic [3:0] OP_LAST = 4'd9;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_FULL = 2'd2
  } size_e;

  function automatic logic op_is_plain_rot(logic [3:0] op);
    return (op == OP_ROTL) || (op == OP_ROTR);
  endfunction

  function automatic logic op_is_ring_rot(logic [3:0] op);
    return (op == OP_RCYL) || (op == OP_RCYR);
  endfunction

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode #(
  parameter int XLEN      = 32,
  parameter int CNT_RAW_W = 8,
  localparam int CNT_W    = $clog2(XLEN),
  localparam int AMT_W    = $clog2(3 * XLEN) + 1
) (
  input  logic [CNT_RAW_W-1:0] count_i,
  input  logic [1:0]           size_i,
  input  logic [3:0]           op_i,
  output logic [AMT_W-1:0]     width_o,
  output logic [AMT_W-1:0]     shift_amt_o,
  output logic [AMT_W-1:0]     rot_amt_o,
  output logic [AMT_W-1:0]     ring_amt_o,
  output logic [XLEN-1:0]      width_mask_o,
  output logic                 cnt_zero_o,
  output logic                 cnt_one_o,
  output logic                 op_legal_o
);
  import shrot_pkg::*;

  localparam logic [CNT_RAW_W-1:0] KEEP = CNT_RAW_W'((1 << CNT_W) - 1);
  localparam int W_BYTE = XLEN / 4;
  localparam int W_HALF = XLEN / 2;

  logic [CNT_RAW_W-1:0] cnt_keep;

  assign cnt_keep    = count_i & KEEP;
  assign cnt_zero_o  = (cnt_keep == '0);
  assign cnt_one_o   = (cnt_keep == CNT_RAW_W'(1));
  assign shift_amt_o = AMT_W'(cnt_keep);
  assign op_legal_o  = (op_i <= OP_LAST);

  always_comb begin
    case (size_i)
      SZ_BYTE: begin
        width_o    = AMT_W'(W_BYTE);
        ring_amt_o = AMT_W'(32'(cnt_keep) % (W_BYTE + 1));
      end
      SZ_HALF: begin
        width_o    = AMT_W'(W_HALF);
        ring_amt_o = AMT_W'(32'(cnt_keep) % (W_HALF + 1));
      end
      default: begin
        width_o    = AMT_W'(XLEN);
        ring_amt_o = AMT_W'(32'(cnt_keep) % (XLEN + 1));
      end
    endcase
  end

  // widths are powers of two, so the plain rotate modulo is a mask
  assign rot_amt_o    = shift_amt_o & (width_o - AMT_W'(1));
  assign width_mask_o = {XLEN{1'b1}} >> (AMT_W'(XLEN) - width_o);

endmodule

// File: rtl/shrot_barrel.sv
module shrot_barrel #(
  parameter int XLEN     = 32,
  localparam int AMT_W   = $clog2(3 * XLEN) + 1,
  localparam int L       = 3 * XLEN
) (
  input  logic [3:0]       op_i,
  input  logic [XLEN-1:0]  dst_i,
  input  logic [XLEN-1:0]  src_i,
  input  logic             carry_i,
  input  logic [AMT_W-1:0] width_i,
  input  logic [AMT_W-1:0] shift_amt_i,
  input  logic [AMT_W-1:0] rot_amt_i,
  input  logic [AMT_W-1:0] ring_amt_i,
  input  logic [XLEN-1:0]  width_mask_i,
  input  logic             cnt_zero_i,
  input  logic             op_legal_i,
  output logic [XLEN-1:0]  res_o,
  output logic             carry_o,
  output logic             res_msb_o,
  output logic             dst_msb_o
);
  import shrot_pkg::*;

  typedef logic [L-1:0] wv_t;

  // rotate within a field of w bits; bits above w are garbage, masked by caller
  function automatic wv_t rot_left(wv_t x, logic [AMT_W-1:0] w, logic [AMT_W-1:0] r);
    return (x << r) | (x >> (w - r));
  endfunction

  function automatic wv_t rot_right(wv_t x, logic [AMT_W-1:0] w, logic [AMT_W-1:0] r);
    return (x >> r) | (x << (w - r));
  endfunction

  function automatic logic bit_at(wv_t x, logic [AMT_W-1:0] idx);
    wv_t t;
    t = x >> idx;
    return t[0];
  endfunction

  wv_t              wmask, dz, sz, ring, sx, pair, v;
  wv_t              res_w;
  logic             cy;
  logic [AMT_W-1:0] ring_w, nm1, two_w;

  assign wmask  = wv_t'(width_mask_i);
  assign dz     = wv_t'(dst_i) & wmask;
  assign sz     = wv_t'(src_i) & wmask;
  assign ring   = dz | (wv_t'(carry_i) << width_i);
  assign ring_w = width_i + AMT_W'(1);
  assign nm1    = shift_amt_i - AMT_W'(1);
  assign two_w  = width_i << 1;
  assign dst_msb_o = bit_at(dz, width_i - AMT_W'(1));
  assign sx     = dst_msb_o ? (dz | ~wmask) : dz;

  always_comb begin
    pair  = '0;
    v     = '0;
    res_w = dz;
    cy    = carry_i;
    case (op_i)
      OP_ROTL: begin
        v     = rot_left(dz, width_i, rot_amt_i);
        res_w = v & wmask;
        cy    = res_w[0];
      end
      OP_ROTR: begin
        v     = rot_right(dz, width_i, rot_amt_i);
        res_w = v & wmask;
        cy    = bit_at(res_w, width_i - AMT_W'(1));
      end
      OP_RCYL: begin
        v     = rot_left(ring, ring_w, ring_amt_i);
        res_w = v & wmask;
        cy    = bit_at(v, width_i);
      end
      OP_RCYR: begin
        v     = rot_right(ring, ring_w, ring_amt_i);
        res_w = v & wmask;
        cy    = bit_at(v, width_i);
      end
      OP_SHL, OP_SAL: begin
        v     = dz << shift_amt_i;
        res_w = v & wmask;
        cy    = bit_at(v, width_i);
      end
      OP_SHR: begin
        res_w = dz >> shift_amt_i;
        cy    = bit_at(dz, nm1);
      end
      OP_SAR: begin
        res_w = (sx >> shift_amt_i) & wmask;
        cy    = bit_at(sx, nm1);
      end
      OP_DSHL: begin
        pair  = (dz << width_i) | sz;
        v     = pair << shift_amt_i;
        res_w = (v >> width_i) & wmask;
        cy    = bit_at(v, two_w);
      end
      OP_DSHR: begin
        pair  = (sz << width_i) | dz;
        res_w = (pair >> shift_amt_i) & wmask;
        cy    = bit_at(pair, nm1);
      end
      default: begin
        res_w = dz;
        cy    = carry_i;
      end
    endcase
    if (cnt_zero_i || !op_legal_i) begin
      res_w = dz;
      cy    = carry_i;
    end
  end

  assign res_o     = XLEN'(res_w);
  assign carry_o   = cy;
  assign res_msb_o = bit_at(res_w, width_i - AMT_W'(1));

endmodule

// File: rtl/shrot_flags.sv
module shrot_flags (
  input  logic op_legal_i,
  input  logic cnt_zero_i,
  input  logic cnt_one_i,
  input  logic res_msb_i,
  input  logic dst_msb_i,
  output logic flags_upd_o,
  output logic ovf_o
);
  assign flags_upd_o = op_legal_i && !cnt_zero_i;
  assign ovf_o       = flags_upd_o && cnt_one_i && (res_msb_i ^ dst_msb_i);
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit #(
  parameter int XLEN      = 32,
  parameter int CNT_RAW_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_i,
  input  logic [3:0]           op_i,
  input  logic [1:0]           size_i,
  input  logic [XLEN-1:0]      dst_i,
  input  logic [XLEN-1:0]      src_i,
  input  logic [CNT_RAW_W-1:0] count_i,
  input  logic                 carry_i,
  output logic [XLEN-1:0]      result_o,
  output logic                 carry_o,
  output logic                 ovf_o,
  output logic                 flags_we_o
);
  localparam int AMT_W = $clog2(3 * XLEN) + 1;

  logic [AMT_W-1:0] width, shift_amt, rot_amt, ring_amt;
  logic [XLEN-1:0]  width_mask;
  logic             cnt_zero, cnt_one, op_legal;
  logic [XLEN-1:0]  res_next;
  logic             carry_next, res_msb, dst_msb;
  logic             flags_upd, ovf_next;

  shrot_decode #(.XLEN(XLEN), .CNT_RAW_W(CNT_RAW_W)) u_dec (
    .count_i      (count_i),
    .size_i       (size_i),
    .op_i         (op_i),
    .width_o      (width),
    .shift_amt_o  (shift_amt),
    .rot_amt_o    (rot_amt),
    .ring_amt_o   (ring_amt),
    .width_mask_o (width_mask),
    .cnt_zero_o   (cnt_zero),
    .cnt_one_o    (cnt_one),
    .op_legal_o   (op_legal)
  );

  shrot_barrel #(.XLEN(XLEN)) u_bar (
    .op_i         (op_i),
    .dst_i        (dst_i),
    .src_i        (src_i),
    .carry_i      (carry_i),
    .width_i      (width),
    .shift_amt_i  (shift_amt),
    .rot_amt_i    (rot_amt),
    .ring_amt_i   (ring_amt),
    .width_mask_i (width_mask),
    .cnt_zero_i   (cnt_zero),
    .op_legal_i   (op_legal),
    .res_o        (res_next),
    .carry_o      (carry_next),
    .res_msb_o    (res_msb),
    .dst_msb_o    (dst_msb)
  );

  shrot_flags u_flg (
    .op_legal_i  (op_legal),
    .cnt_zero_i  (cnt_zero),
    .cnt_one_i   (cnt_one),
    .res_msb_i   (res_msb),
    .dst_msb_i   (dst_msb),
    .flags_upd_o (flags_upd),
    .ovf_o       (ovf_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o   <= '0;
      carry_o    <= 1'b0;
      ovf_o      <= 1'b0;
      flags_we_o <= 1'b0;
    end else begin
      flags_we_o <= issue_i && flags_upd;
      if (issue_i) begin
        result_o <= res_next;
        carry_o  <= carry_next;
        ovf_o    <= ovf_next;
      end
    end
  end

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic [3:0]      op_i,
  input logic [1:0]      size_i,
  input logic [XLEN-1:0] dst_i,
  input logic            carry_i,
  input logic            cnt_zero,
  input logic            cnt_one,
  input logic            flags_upd,
  input logic [XLEN-1:0] width_mask,
  input logic [XLEN-1:0] result_o,
  input logic            carry_o,
  input logic            ovf_o,
  input logic            flags_we_o
);
  import shrot_pkg::*;

  // R1: a zero masked count passes the destination and carry through
  a_r1_zero_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && cnt_zero |=> (result_o == $past(dst_i & width_mask))
                            && (carry_o == $past(carry_i)) && !flags_we_o && !ovf_o);

  // R2: a plain rotate keeps the number of set bits
  a_r2_rot_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && flags_upd && op_is_plain_rot(op_i)
    |=> $countones(result_o) == $past($countones(dst_i & width_mask)));

  // R3: a rotate through carry keeps the set bits of the carry-extended ring
  a_r3_ring_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && flags_upd && op_is_ring_rot(op_i)
    |=> ($countones(result_o) + 32'(carry_o))
        == $past($countones(dst_i & width_mask) + 32'(carry_i)));

  // R8: overflow only for a count of one
  a_r8_ovf_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && !cnt_one |=> !ovf_o);

  // R9: byte results are zero above bit 7
  a_r9_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i && (size_i == SZ_BYTE) |=> result_o[XLEN-1:XLEN/4] == '0);

  // R11: no flag write without an issue in the prior cycle
  a_r11_we_needs_issue: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !flags_we_o);

  // R11: outputs hold between issues
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(result_o) && $stable(carry_o) && $stable(ovf_o));

endmodule

bind shrot_unit shrot_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .issue_i    (issue_i),
  .op_i       (op_i),
  .size_i     (size_i),
  .dst_i      (dst_i),
  .carry_i    (carry_i),
  .cnt_zero   (cnt_zero),
  .cnt_one    (cnt_one),
  .flags_upd  (flags_upd),
  .width_mask (width_mask),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .ovf_o      (ovf_o),
  .flags_we_o (flags_we_o)
);

// File: tb/shrot_unit_test.sv
module shrot_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] dst_i = '0;
  logic [31:0] src_i = '0;
  logic [7:0]  count_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o, ovf_o, flags_we_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5ns clk = ~clk;

  shrot_unit uut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .size_i(size_i),
    .dst_i(dst_i), .src_i(src_i), .count_i(count_i), .carry_i(carry_i),
    .result_o(result_o), .carry_o(carry_o), .ovf_o(ovf_o), .flags_we_o(flags_we_o)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [1:0]  sz;
    logic [7:0]  cnt;
    logic        ci;
    logic [31:0] d;
    logic [31:0] s;
    logic [31:0] er;
    logic        ec;
    logic        eo;
    logic        ev;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 2'd0, 8'd1,    1'b0, 32'h81,       32'h0,    32'h03,       1'b1, 1'b1, 1'b1, 4'd2},  // R2 rotl, R8
    '{4'd1, 2'd0, 8'd1,    1'b0, 32'h01,       32'h0,    32'h80,       1'b1, 1'b1, 1'b1, 4'd2},  // R2 rotr
    '{4'd2, 2'd0, 8'd1,    1'b0, 32'h80,       32'h0,    32'h00,       1'b1, 1'b1, 1'b1, 4'd3},  // R3 top to carry
    '{4'd2, 2'd0, 8'd1,    1'b1, 32'h00,       32'h0,    32'h01,       1'b0, 1'b0, 1'b1, 4'd3},  // R3 carry to bit 0
    '{4'd3, 2'd0, 8'd1,    1'b1, 32'h01,       32'h0,    32'h80,       1'b1, 1'b1, 1'b1, 4'd3},  // R3 carry to top
    '{4'd2, 2'd0, 8'd9,    1'b1, 32'h5A,       32'h0,    32'h5A,       1'b1, 1'b0, 1'b1, 4'd3},  // R3 mod width+1
    '{4'd4, 2'd1, 8'd4,    1'b0, 32'h1001,     32'h0,    32'h0010,     1'b1, 1'b0, 1'b1, 4'd4},  // R4
    '{4'd6, 2'd0, 8'd1,    1'b0, 32'h40,       32'h0,    32'h80,       1'b0, 1'b1, 1'b1, 4'd4},  // R4 alt code, R8
    '{4'd4, 2'd0, 8'd8,    1'b0, 32'hFF,       32'h0,    32'h00,       1'b1, 1'b0, 1'b1, 4'd4},  // R4 count = width
    '{4'd5, 2'd2, 8'd2,    1'b0, 32'h80000003, 32'h0,    32'h20000000, 1'b1, 1'b0, 1'b1, 4'd5},  // R5
    '{4'd5, 2'd0, 8'd12,   1'b1, 32'hF0,       32'h0,    32'h00,       1'b0, 1'b0, 1'b1, 4'd5},  // R5 past width
    '{4'd7, 2'd0, 8'd3,    1'b0, 32'h84,       32'h0,    32'hF0,       1'b1, 1'b0, 1'b1, 4'd6},  // R6
    '{4'd7, 2'd0, 8'd1,    1'b0, 32'h80,       32'h0,    32'hC0,       1'b0, 1'b0, 1'b1, 4'd8},  // R8 sign kept
    '{4'd8, 2'd1, 8'd4,    1'b0, 32'h1234,     32'hABCD, 32'h234A,     1'b1, 1'b0, 1'b1, 4'd7},  // R7 left
    '{4'd9, 2'd1, 8'd4,    1'b0, 32'h1234,     32'hABCD, 32'hD123,     1'b0, 1'b0, 1'b1, 4'd7},  // R7 right
    '{4'd4, 2'd0, 8'h20,   1'b1, 32'h55,       32'h0,    32'h55,       1'b1, 1'b0, 1'b0, 4'd1},  // R1 masks to 0
    '{4'd4, 2'd0, 8'hE1,   1'b0, 32'h01,       32'h0,    32'h02,       1'b0, 1'b0, 1'b1, 4'd1},  // R1 masks to 1
    '{4'd12, 2'd2, 8'd3,   1'b0, 32'hDEADBEEF, 32'h0,    32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 4'd10}, // R10
    '{4'd0, 2'd2, 8'd31,   1'b0, 32'h80000000, 32'h0,    32'h40000000, 1'b0, 1'b0, 1'b1, 4'd2},  // R2 full word
    '{4'd0, 2'd0, 8'd8,    1'b0, 32'hA5,       32'h0,    32'hA5,       1'b1, 1'b0, 1'b1, 4'd2},  // R2 multiple of width
    '{4'd1, 2'd0, 8'd4,    1'b0, 32'hFFFFFF12, 32'h0,    32'h21,       1'b0, 1'b0, 1'b1, 4'd9},  // R9 upper zero
    '{4'd1, 2'd3, 8'd1,    1'b0, 32'h00000001, 32'h0,    32'h80000000, 1'b1, 1'b1, 1'b1, 4'd9}   // R9 code 3
  };

  // step-by-step model: applies one position per iteration
  function automatic void ref_op(input logic [3:0] op, input logic [1:0] sz,
                                 input logic [7:0] cnt, input logic ci,
                                 input logic [31:0] d, input logic [31:0] s,
                                 output logic [31:0] r, output logic c,
                                 output logic o, output logic v);
    int          w;
    int          n;
    logic [31:0] m, x, y;
    logic        cy, b, top0;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    m = (w == 32) ? 32'hFFFFFFFF : ((32'd1 << w) - 32'd1);
    n = int'(cnt & 8'h1F);
    x = d & m;
    y = s & m;
    cy = ci;
    top0 = x[w-1];
    if (n == 0 || op > 4'd9) begin
      r = x; c = ci; o = 1'b0; v = 1'b0;
      return;
    end
    for (int k = 0; k < n; k++) begin
      case (op)
        4'd0: begin cy = x[w-1]; x = ((x << 1) | 32'(cy)) & m; end
        4'd1: begin cy = x[0];   x = (x >> 1) | (32'(cy) << (w-1)); end
        4'd2: begin b = x[w-1];  x = ((x << 1) | 32'(cy)) & m; cy = b; end
        4'd3: begin b = x[0];    x = (x >> 1) | (32'(cy) << (w-1)); cy = b; end
        4'd4, 4'd6: begin cy = x[w-1]; x = (x << 1) & m; end
        4'd5: begin cy = x[0]; x = x >> 1; end
        4'd7: begin cy = x[0]; x = (x >> 1) | (32'(x[w-1]) << (w-1)); end
        4'd8: begin cy = x[w-1]; x = ((x << 1) | 32'(y[w-1])) & m; y = (y << 1) & m; end
        default: begin cy = x[0]; x = (x >> 1) | (32'(y[0]) << (w-1)); y = y >> 1; end
      endcase
    end
    r = x;
    c = cy;
    o = (n == 1) && (x[w-1] != top0);
    v = 1'b1;
  endfunction

  function automatic int tag_of(logic [3:0] op, logic [7:0] cnt);
    if ((cnt & 8'h1F) == 8'h00) return 1;
    if (op > 4'd9) return 10;
    if (op < 4'd2) return 2;
    if (op < 4'd4) return 3;
    if (op == 4'd4 || op == 4'd6) return 4;
    if (op == 4'd5) return 5;
    if (op == 4'd7) return 6;
    return 7;
  endfunction

  task automatic check(input int tag, input string what,
                       input logic [31:0] gr, input logic gc, input logic go, input logic gv,
                       input logic [31:0] er, input logic ec, input logic eo, input logic ev);
    n_checks++;
    if (gr !== er || gc !== ec || go !== eo || gv !== ev) begin
      n_fail++;
      $display("FAIL R%0d %s: got res=%h c=%b o=%b we=%b, expected res=%h c=%b o=%b we=%b",
               tag, what, gr, gc, go, gv, er, ec, eo, ev);
    end
  endtask

  // drives one issue cycle and returns after the registered outputs settle
  task automatic issue_op(input logic [3:0] op, input logic [1:0] sz, input logic [7:0] cnt,
                          input logic ci, input logic [31:0] d, input logic [31:0] s);
    @(negedge clk);
    issue_i = 1'b1; op_i = op; size_i = sz; count_i = cnt; carry_i = ci;
    dst_i = d; src_i = s;
    @(negedge clk);
    issue_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R11 watchdog expired: got running, expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] er, lfsr;
    logic        ec, eo, ev;
    logic [31:0] held_r;
    logic        held_c, held_o;

    // R11: reset clears everything
    repeat (3) @(negedge clk);
    check(11, "reset state", result_o, carry_o, ovf_o, flags_we_o, 32'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;

    foreach (VECS[i]) begin
      issue_op(VECS[i].op, VECS[i].sz, VECS[i].cnt, VECS[i].ci, VECS[i].d, VECS[i].s);
      check(int'(VECS[i].tag), $sformatf("vector %0d", i), result_o, carry_o, ovf_o, flags_we_o,
            VECS[i].er, VECS[i].ec, VECS[i].eo, VECS[i].ev);
    end

    // R11: outputs hold and strobe drops while idle
    issue_op(4'd4, 2'd2, 8'd1, 1'b0, 32'hC0000001, 32'h0);
    held_r = result_o; held_c = carry_o; held_o = ovf_o;
    check(11, "issue result", result_o, carry_o, ovf_o, flags_we_o, 32'h80000002, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    dst_i = 32'h12345678; count_i = 8'd3;
    @(negedge clk);
    check(11, "idle hold", result_o, carry_o, ovf_o, flags_we_o, held_r, held_c, held_o, 1'b0);

    // sweep against the step model
    lfsr = 32'h1ACE5EED;
    for (int it = 0; it < 1500; it++) begin
      logic [3:0]  op;
      logic [1:0]  sz;
      logic [7:0]  cnt;
      logic        ci;
      logic [31:0] d, s;
      lfsr ^= lfsr << 13; lfsr ^= lfsr >> 17; lfsr ^= lfsr << 5;
      op  = 4'(lfsr[3:0] % 4'd12);
      sz  = lfsr[5:4];
      cnt = (lfsr[6]) ? {3'b000, lfsr[11:7]} : lfsr[15:8];
      ci  = lfsr[16];
      d   = lfsr ^ 32'h9E3779B9;
      s   = {lfsr[15:0], lfsr[31:16]};
      ref_op(op, sz, cnt, ci, d, s, er, ec, eo, ev);
      issue_op(op, sz, cnt, ci, d, s);
      check(tag_of(op, cnt), $sformatf("sweep op=%0d sz=%0d cnt=%0d", op, sz, cnt),
            result_o, carry_o, ovf_o, flags_we_o, er, ec, eo, ev);
    end

    done = 1'b1;
    finish_run();
  end

endmodule